// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns read and write commands into a stream of column addresses, one per clock, and produces the write-enable and read-data-valid timing that goes with each beat. It belongs in the datapath of a synchronous DRAM device model or controller. The memory array, refresh, row timing and pad details are handled elsewhere.

A mode-set command copies burst settings from the address bus into an internal mode register. The settings are burst length, burst ordering, read latency and write-burst mode. A read or write command then latches a bank and a starting column. The block emits the burst columns in the programmed order and delays read-data-valid by the programmed latency. A per-beat mask input gates write enables immediately and read output enables two clocks later. A new read or write cuts short any burst still in progress.

Top module: `sdram_burst_seq`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, col_valid_o, wr_en_o, rd_valid_o and rd_oe_o are all low.
- R2: cmd_i encodes 0 as no-op, 1 as mode set, 2 as read and 3 as write. A mode set loads from addr_i: bits [2:0] burst length (0→1, 1→2, 2→4, 3→8 beats), bit 3 ordering (0 sequential, 1 interleaved), bits [6:4] read latency (2 or 3 clocks) and bit 9 single-beat writes. A reserved length code (4 to 7) leaves the length unchanged, and a reserved latency code leaves the latency unchanged. After reset the settings are 1 beat, sequential, latency 3 and burst writes.
- R3: A read or write sampled at edge E drives col_valid_o high after edge E with col_o equal to addr_i[COL_W-1:0], bank_o equal to bank_i and col_wr_o set for a write. Beat k follows after edge E+k, for one beat per clock over the burst length, with bank and direction held.
- R4: In sequential order, beat k has low column bits ((s mod L)+k) mod L inside the aligned block of L columns that holds start column s. The upper bits are unchanged.
- R5: In interleaved order, the low column bits of beat k are (s mod L) XOR k, and the upper bits are unchanged.
- R6: For a read beat shown after edge E+k, rd_valid_o is high after edge E+k+CL-1, where CL is the programmed latency.
- R7: With single-beat writes selected, a write emits exactly one beat while reads still use the programmed length.
- R8: wr_en_o goes high together with a write beat shown after edge n only if dqm_i was low when sampled at edge n. This is zero latency: the mask driven with a write command covers beat 0.
- R9: rd_oe_o after edge n equals rd_valid_o after edge n AND NOT dqm_i as sampled at edge n-1. This is a two-clock mask latency.
- R10: A read or write command accepted during a burst ends the old burst at once, and read beats of the old burst that were not yet emitted never raise rd_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Command code |
| bank_i | input | BANK_W | Bank select latched with read or write |
| addr_i | input | ADDR_W | Start column, or mode value on a mode set |
| dqm_i | input | 1 | Per-beat data mask |
| col_valid_o | output | 1 | A burst beat is presented |
| col_o | output | COL_W | Column for the current beat |
| bank_o | output | BANK_W | Bank of the current burst |
| col_wr_o | output | 1 | Current burst is a write |
| wr_en_o | output | 1 | Unmasked write beat |
| rd_valid_o | output | 1 | Read data valid after latency |
| rd_oe_o | output | 1 | Read data driven (not masked) |

## Verification
Each column beat is due one edge after its command edge plus its beat index. wr_en_o is due on that same edge and is gated by the mask sampled at that edge. rd_valid_o is due CL-1 edges after the beat's column, and rd_oe_o on the same edge but gated by the mask sampled one edge earlier. The bench keeps a slot table indexed by edge number, fills it with these offsets when it issues each command, clears slots when a command truncates a burst, and compares every output with its slot at the falling edge after each rising edge. Mode changes are issued only once every scheduled slot has passed, so each slot is computed with a single latency.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  localparam int MAX_CL = 3;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_MODE  = 2'd1,
    CMD_READ  = 2'd2,
    CMD_WRITE = 2'd3
  } cmd_e;

  typedef struct packed {
    logic [1:0] len_lg;     // log2 of burst length
    logic       interleave; // 1 = interleaved ordering
    logic [1:0] cas;        // read latency in clocks (2 or 3)
    logic       single_wr;  // 1 = writes are one beat
  } mode_t;
endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output mode_t             mode_o
);
  logic len_ok, cas_ok;

  assign len_ok = (addr_i[2] == 1'b0);
  assign cas_ok = (addr_i[6:4] == 3'b010) || (addr_i[6:4] == 3'b011);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o.len_lg     <= 2'd0;
      mode_o.interleave <= 1'b0;
      mode_o.cas        <= 2'd3;
      mode_o.single_wr  <= 1'b0;
    end else if (load_i) begin
      if (len_ok) mode_o.len_lg <= addr_i[1:0];
      mode_o.interleave <= addr_i[3];
      if (cas_ok) mode_o.cas <= addr_i[5:4];
      mode_o.single_wr <= addr_i[9];
    end
  end
endmodule

// File: rtl/sdram_burst_gen.sv
module sdram_burst_gen
  import sdram_seq_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              dqm_i,
  input  mode_t             mode_i,
  output logic              col_valid_o,
  output logic [COL_W-1:0]  col_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              col_wr_o,
  output logic              wr_en_o
);
  localparam int CNT_W = 3;

  logic             active;
  logic [CNT_W-1:0] cnt, last_q, new_last;
  logic             il_q;
  logic [COL_W-1:0] start_q;
  logic             is_rw, is_wr;

  assign is_wr    = (cmd_e'(cmd_i) == CMD_WRITE);
  assign is_rw    = is_wr || (cmd_e'(cmd_i) == CMD_READ);
  assign new_last = (is_wr && mode_i.single_wr) ? '0
                  : CNT_W'((4'd1 << mode_i.len_lg) - 4'd1);

  function automatic logic [COL_W-1:0] beat_col(
    input logic [COL_W-1:0] s, input logic [CNT_W-1:0] k,
    input logic [CNT_W-1:0] lst, input logic il);
    logic [COL_W-1:0] m, kk;
    m  = {{(COL_W-CNT_W){1'b0}}, lst};
    kk = {{(COL_W-CNT_W){1'b0}}, k};
    if (il) beat_col = (s & ~m) | ((s ^ kk) & m);
    else    beat_col = (s & ~m) | ((s + kk) & m);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      active      <= 1'b0;
      cnt         <= '0;
      last_q      <= '0;
      il_q        <= 1'b0;
      start_q     <= '0;
      col_valid_o <= 1'b0;
      col_o       <= '0;
      bank_o      <= '0;
      col_wr_o    <= 1'b0;
      wr_en_o     <= 1'b0;
    end else if (is_rw) begin
      start_q     <= col_i;
      bank_o      <= bank_i;
      col_wr_o    <= is_wr;
      il_q        <= mode_i.interleave;
      last_q      <= new_last;
      cnt         <= CNT_W'(1);
      active      <= (new_last != '0);
      col_valid_o <= 1'b1;
      col_o       <= col_i;
      wr_en_o     <= is_wr && !dqm_i;
    end else if (active) begin
      col_o       <= beat_col(start_q, cnt, last_q, il_q);
      cnt         <= cnt + CNT_W'(1);
      active      <= (cnt != last_q);
      col_valid_o <= 1'b1;
      wr_en_o     <= col_wr_o && !dqm_i;
    end else begin
      col_valid_o <= 1'b0;
      wr_en_o     <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
  parameter int MAX_CL = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       beat_i,
  input  logic       dqm_i,
  input  logic [1:0] cas_i,
  output logic       rd_valid_o,
  output logic       rd_oe_o
);
  localparam int NT = MAX_CL - 1;
  localparam int SW = (NT > 1) ? $clog2(NT) : 1;

  logic [NT-1:0] taps;
  logic [NT-1:1] sh;
  logic [SW-1:0] sel;
  logic          dqm_q, pre;

  assign taps = {sh, beat_i};
  assign sel  = SW'(cas_i - 2'd2);
  assign pre  = taps[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh         <= '0;
      dqm_q      <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_oe_o    <= 1'b0;
    end else begin
      sh         <= taps[NT-2:0];
      dqm_q      <= dqm_i;
      rd_valid_o <= pre;
      rd_oe_o    <= pre && !dqm_q;
    end
  end
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int COL_W  = 10,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dqm_i,
  output logic              col_valid_o,
  output logic [COL_W-1:0]  col_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              col_wr_o,
  output logic              wr_en_o,
  output logic              rd_valid_o,
  output logic              rd_oe_o
);
  mode_t mode;
  logic  rd_beat;

  sdram_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
    .clk(clk), .rst(rst),
    .load_i(cmd_e'(cmd_i) == CMD_MODE),
    .addr_i(addr_i), .mode_o(mode)
  );

  sdram_burst_gen #(.COL_W(COL_W), .BANK_W(BANK_W)) u_gen (
    .clk(clk), .rst(rst), .cmd_i(cmd_i), .bank_i(bank_i),
    .col_i(addr_i[COL_W-1:0]), .dqm_i(dqm_i), .mode_i(mode),
    .col_valid_o(col_valid_o), .col_o(col_o), .bank_o(bank_o),
    .col_wr_o(col_wr_o), .wr_en_o(wr_en_o)
  );

  assign rd_beat = col_valid_o && !col_wr_o;

  sdram_rd_pipe #(.MAX_CL(MAX_CL)) u_rd (
    .clk(clk), .rst(rst), .beat_i(rd_beat), .dqm_i(dqm_i),
    .cas_i(mode.cas), .rd_valid_o(rd_valid_o), .rd_oe_o(rd_oe_o)
  );
endmodule

// File: rtl/sdram_burst_seq_chk.sv
module sdram_burst_seq_chk #(
  parameter int ADDR_W = 12,
  parameter int COL_W  = 10,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cmd_i,
  input logic [BANK_W-1:0] bank_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              col_valid_o,
  input logic [COL_W-1:0]  col_o,
  input logic [BANK_W-1:0] bank_o,
  input logic              col_wr_o,
  input logic              wr_en_o,
  input logic              rd_valid_o,
  input logic              rd_oe_o
);
  logic rw_cmd, rd_beat;
  assign rw_cmd  = cmd_i[1];
  assign rd_beat = col_valid_o && !col_wr_o;

  a_r3_cmd_starts: assert property (@(posedge clk) disable iff (rst)
    rw_cmd |=> col_valid_o && col_o == $past(addr_i[COL_W-1:0]) && bank_o == $past(bank_i));

  a_r3_bank_held: assert property (@(posedge clk) disable iff (rst)
    (col_valid_o && $past(col_valid_o) && !$past(rw_cmd)) |-> bank_o == $past(bank_o));

  a_r8_wr_en_on_write: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> col_valid_o && col_wr_o);

  a_r9_oe_needs_valid: assert property (@(posedge clk) disable iff (rst)
    rd_oe_o |-> rd_valid_o);

  a_r6_valid_from_read: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> ($past(rd_beat) || $past(rd_beat, 2)));
endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(
  .ADDR_W(ADDR_W), .COL_W(COL_W), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst(rst), .cmd_i(cmd_i), .bank_i(bank_i), .addr_i(addr_i),
  .col_valid_o(col_valid_o), .col_o(col_o), .bank_o(bank_o),
  .col_wr_o(col_wr_o), .wr_en_o(wr_en_o), .rd_valid_o(rd_valid_o),
  .rd_oe_o(rd_oe_o)
);

// File: tb/sdram_burst_seq_tb.sv
`timescale 1ns/1ps
module sdram_burst_seq_tb;
  localparam int NS = 8192;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] cmd = 2'd0;
  logic [1:0] bank = 2'd0;
  logic [11:0] addr = '0;
  logic dqm = 1'b0;
  logic col_valid, col_wr, wr_en, rd_valid, rd_oe;
  logic [9:0] col;
  logic [1:0] bank_out;

  always #2.5 clk = ~clk;

  sdram_burst_seq u_dut (
    .clk(clk), .rst(rst), .cmd_i(cmd), .bank_i(bank), .addr_i(addr),
    .dqm_i(dqm), .col_valid_o(col_valid), .col_o(col), .bank_o(bank_out),
    .col_wr_o(col_wr), .wr_en_o(wr_en), .rd_valid_o(rd_valid), .rd_oe_o(rd_oe)
  );

  int n_tests = 0, n_fail = 0, edge_n = 0, busy_until = 0;
  bit done = 0;
  bit exp_cv[NS], exp_wr[NS], exp_rv[NS], dqm_at[NS];
  int exp_col[NS], exp_bank[NS];
  int m_len_lg = 0, m_il = 0, m_cl = 3, m_single = 0;

  task automatic chk(string req, int n, int got, int want);
    n_tests++;
    if (got != want) begin
      n_fail++;
      $display("FAIL %s at edge %0d: got %0h expected %0h", req, n, got, want);
    end
  endtask

  function automatic int model_col(int s, int k, int len, int il);
    int base = s - (s % len);
    int low  = s % len;
    if (il != 0) return base + (low ^ k);
    return base + ((low + k) % len);
  endfunction

  task automatic schedule(int e, int c, int b, int a);
    int len, s;
    if (c == 1) begin
      if (a[2] == 1'b0) m_len_lg = a[1:0];
      m_il = a[3];
      if (a[6:4] == 3'd2 || a[6:4] == 3'd3) m_cl = a[6:4];
      m_single = a[9];
      return;
    end
    if (c < 2) return;
    for (int i = 0; i < 9; i++) begin
      exp_cv[e+i] = 0;
      exp_rv[e+m_cl-1+i] = 0;  // R10: cancelled beats
    end
    len = (c == 3 && m_single != 0) ? 1 : (1 << m_len_lg);
    s = a[9:0];
    for (int k = 0; k < len; k++) begin
      exp_cv[e+k]   = 1;
      exp_col[e+k]  = model_col(s, k, len, m_il);
      exp_bank[e+k] = b;
      exp_wr[e+k]   = (c == 3);
      if (c == 2) exp_rv[e+k+m_cl-1] = 1;
      if (e + k + m_cl - 1 > busy_until) busy_until = e + k + m_cl - 1;
    end
  endtask

  task automatic check_slot(int n);
    chk("R3 col_valid", n, col_valid, exp_cv[n]);
    if (exp_cv[n]) begin
      chk("R4/R5 column", n, col, exp_col[n]);
      chk("R3 bank", n, bank_out, exp_bank[n]);
      chk("R3 direction", n, col_wr, exp_wr[n]);
    end
    chk("R8 wr_en", n, wr_en, exp_cv[n] && exp_wr[n] && !dqm_at[n]);
    chk("R6 rd_valid", n, rd_valid, exp_rv[n]);
    chk("R9 rd_oe", n, rd_oe, exp_rv[n] && !dqm_at[n-1]);
  endtask

  task automatic step(int c, int b, int a, bit d);
    cmd = c[1:0]; bank = b[1:0]; addr = a[11:0]; dqm = d;
    dqm_at[edge_n+1] = d;
    schedule(edge_n + 1, c, b, a);
    @(posedge clk);
    edge_n++;
    @(negedge clk);
    check_slot(edge_n);
  endtask

  task automatic idle(int cycles);
    for (int i = 0; i < cycles; i++) step(0, 0, 0, 0);
  endtask

  task automatic mode_set(int a);
    while (edge_n + 1 <= busy_until) step(0, 0, 0, 0);
    step(1, 0, a, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs low during reset
    chk("R1 col_valid", 0, col_valid, 0);
    chk("R1 wr_en", 0, wr_en, 0);
    chk("R1 rd_valid", 0, rd_valid, 0);
    chk("R1 rd_oe", 0, rd_oe, 0);
    rst = 0;
    idle(1);  // R1: cycle after release still low

    // R2 defaults: 1 beat, latency 3
    step(2, 1, 12'h123, 0);
    idle(4);
    // R2: burst 8 sequential, latency 2; R4 wrap inside block
    mode_set(12'h023);
    step(2, 2, 12'h03D, 0);
    idle(10);
    // R5: interleaved length 4, latency 3
    mode_set(12'h03A);
    step(2, 3, 12'h1F6, 0);
    idle(6);
    // R9: read mask with two clocks latency
    step(2, 0, 12'h011, 1);
    step(0, 0, 0, 0);
    step(0, 0, 0, 1);
    idle(6);
    // R8: write with masked beats
    step(3, 1, 12'h2A1, 1);
    step(0, 0, 0, 0);
    step(0, 0, 0, 1);
    idle(4);
    // R7: single-beat writes, reads keep length
    mode_set(12'h222);
    step(3, 2, 12'h0F7, 0);
    idle(3);
    step(2, 2, 12'h0F7, 0);
    idle(6);
    // R2: reserved codes (length 5, latency 1) change neither field
    mode_set(12'h01D);
    step(2, 1, 12'h005, 0);
    idle(8);
    // R10: truncation of read by read and by write
    mode_set(12'h023);
    step(2, 0, 12'h100, 0);
    idle(2);
    step(2, 1, 12'h208, 0);
    idle(3);
    step(3, 3, 12'h30C, 0);
    idle(10);

    // random mix
    void'($urandom(32'd7));
    for (int i = 0; i < 2500; i++) begin
      int r = int'($urandom_range(0, 99));
      int a = int'($urandom_range(0, 4095));
      bit d = ($urandom_range(0, 3) == 0);
      if (r < 5) mode_set(a);
      else if (r < 22) step(2, int'($urandom_range(0, 3)), a, d);
      else if (r < 38) step(3, int'($urandom_range(0, 3)), a, d);
      else step(0, 0, 0, d);
    end
    idle(12);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule